// File: doc/BRIEF.md
# Interleaved SHA-256 Compression Engine

The engine applies the SHA-256 compression function to a 512-bit message block. It starts from a 256-bit chaining value that the caller supplies, and it returns the 256-bit result together with a caller-chosen tag. It has a single round datapath. That datapath is cut into four register stages, and four independent blocks circulate through it, one block in each stage. A block gains one round for every lap of four cycles. With all four slots occupied, every stage does useful work on every cycle.

A caller that hashes a long message feeds each block with the previous result as its chaining value. When the double flag is set on entry, the first result is padded into a one-block message, which is then hashed from the standard initial value. Only the second result is presented.

Top module: `sha256_ring_engine`

## Requirements
- R1: A block is taken on a rising edge where `inValid` and `inReady` are both high. An offer made while `inReady` is low is held off without effect and is taken on the first edge where `inReady` is high.
- R2: For a single hash, `outDigest` is the chaining value plus the result of 64 rounds over the block, with each 32-bit word added separately. Words are big-endian in both directions. Block word 0 is in `inBlock[511:480]`, chaining word H0 is in `inChain[255:224]`, and digest word H0 is in `outDigest[255:224]`.
- R3: For a single hash, `outValid` is high for exactly one cycle, 260 clock edges after the accepting edge.
- R4: Up to four blocks can be in flight at once. After four acceptances on consecutive edges, `inReady` is low. Results come out in acceptance order, each with the tag given at entry.
- R5: With `inDouble` set, the only result presented is SHA-256 of the first result. That first result is padded as word 8 = 0x80000000, words 9 to 14 = 0 and word 15 = 256, and it is hashed from the standard initial value. The result appears 520 edges after acceptance.
- R6: The chaining input is honoured, so feeding a block's result in as the next block's chaining value yields the digest of a two-block message.
- R7: A synchronous reset frees all four slots. After reset `outValid` is low and `inReady` is high.
- R8: A slot is freed on the edge that presents its digest. With the ring full, a waiting offer is taken 4 edges after the first acceptance's digest edge, which is 264 edges after that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A block is offered |
| inReady | output | 1 | The slot at the entry boundary is free |
| inDouble | input | 1 | Hash the result a second time |
| inTag | input | TAG_W | Caller tag that returns with the result |
| inChain | input | 256 | Chaining value, H0 in the top word |
| inBlock | input | 512 | Message block, word 0 in the top word |
| outValid | output | 1 | One-cycle result strobe |
| outTag | output | TAG_W | Tag of the presented result |
| outDigest | output | 256 | Result, H0 in the top word |

## Verification
The hardest state to reach from the ports is a full ring in which a fifth offer stays pending until a slot is freed. The stimulus reaches it by offering four blocks on back-to-back edges and keeping a fifth offer raised. The edge on which the fifth offer is accepted then shows when the freed slot reaches the entry boundary. The last block of the burst is the first block of a two-block message. Its result is fed back as a chaining value, which exercises the chaining path with live data.

// File: rtl/sha_ring_pkg.sv
package sha_ring_pkg;
  localparam int STAGES = 4;
  localparam int ROUNDS = 64;
  localparam int RW = $clog2(ROUNDS + 1);
  localparam int KW = $clog2(ROUNDS);
  localparam logic [RW-1:0] LAST_RND = RW'(ROUNDS);

  typedef logic [31:0] word_t;

  typedef struct packed {
    logic          busy;
    logic          idle;    // lap spent loading, no round work
    logic          dbl;
    logic          second;
    logic [RW-1:0] round;
  } ctlRec_t;

  typedef struct packed {
    logic          load;
    logic          ffwd;
    logic          rehash;
    logic          run3;
    logic [KW-1:0] kIdx;
  } strobe_t;

  typedef struct packed {
    logic [7:0][31:0]  st;   // st[0]=a .. st[7]=h
    logic [15:0][31:0] w;    // w[0] is the current round word
    logic [7:0][31:0]  cv;   // saved chaining value
    word_t pa, pb, pz, sa, sb;
  } dpRec_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic word_t bigSig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction
  function automatic word_t bigSig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction
  function automatic word_t smallSig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction
  function automatic word_t smallSig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
  function automatic word_t chooseF(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction
  function automatic word_t majF(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic word_t ivWord(input logic [2:0] i);
    case (i)
      3'd0: return 32'h6a09e667; 3'd1: return 32'hbb67ae85;
      3'd2: return 32'h3c6ef372; 3'd3: return 32'ha54ff53a;
      3'd4: return 32'h510e527f; 3'd5: return 32'h9b05688c;
      3'd6: return 32'h1f83d9ab; default: return 32'h5be0cd19;
    endcase
  endfunction

  function automatic word_t kConst(input logic [KW-1:0] t);
    case (t)
      6'd0: return 32'h428a2f98;  6'd1: return 32'h71374491;  6'd2: return 32'hb5c0fbcf;  6'd3: return 32'he9b5dba5;
      6'd4: return 32'h3956c25b;  6'd5: return 32'h59f111f1;  6'd6: return 32'h923f82a4;  6'd7: return 32'hab1c5ed5;
      6'd8: return 32'hd807aa98;  6'd9: return 32'h12835b01;  6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe; 6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786; 6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa; 6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d; 6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147; 6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138; 6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb; 6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b; 6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624; 6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08; 6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a; 6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f; 6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb; 6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction
endpackage

// File: rtl/sha_ring_ctrl.sv
module sha_ring_ctrl
  import sha_ring_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inDouble,
  input  logic [TAG_W-1:0] inTag,
  output logic             inReady,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag,
  output strobe_t          stb
);
  ctlRec_t ring [STAGES];
  logic [TAG_W-1:0] tagRing [STAGES];
  ctlRec_t q, p, n0, n3;

  always_comb begin
    q = ring[STAGES-1];
    p = ring[STAGES-2];
    stb = '0;
    stb.load   = inValid && !q.busy;
    stb.ffwd   = q.busy && !q.idle && (q.round == LAST_RND);
    stb.rehash = stb.ffwd && q.dbl && !q.second;
    stb.run3   = p.busy && !p.idle && (p.round != LAST_RND);
    stb.kIdx   = q.round[KW-1:0];
    // entry boundary: load, restart for the second hash, or release
    n0 = q;
    if (stb.load) begin
      n0.busy = 1'b1; n0.idle = 1'b1; n0.dbl = inDouble;
      n0.second = 1'b0; n0.round = '0;
    end else if (stb.rehash) begin
      n0.idle = 1'b1; n0.second = 1'b1; n0.round = '0;
    end else if (stb.ffwd) begin
      n0.busy = 1'b0;
    end
    // last stage commits the round
    n3 = p;
    if (p.busy && p.idle) n3.idle = 1'b0;
    else if (stb.run3)    n3.round = p.round + RW'(1);
  end

  assign inReady = !q.busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) ring[i] <= '0;
      outValid <= 1'b0;
      outTag   <= '0;
    end else begin
      ring[0] <= n0;
      for (int i = 1; i < STAGES - 1; i++) ring[i] <= ring[i-1];
      ring[STAGES-1] <= n3;
      outValid <= stb.ffwd && !stb.rehash;
      if (stb.ffwd && !stb.rehash) outTag <= tagRing[STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    tagRing[0] <= stb.load ? inTag : tagRing[STAGES-1];
    for (int i = 1; i < STAGES; i++) tagRing[i] <= tagRing[i-1];
  end

  // R1: an accepted block enters the ring as a fresh, busy slot
  a_r1_accept_fresh: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (ring[0].busy && ring[0].idle && ring[0].round == '0 && !ring[0].second));
  // R8: presenting a digest frees its slot on the same edge
  a_r8_release_on_present: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !ring[0].busy);
  // R7: the first cycle after reset shows a free entry and no result
  a_r7_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (inReady && !outValid));
  // R3: no slot ever runs past the final round
  a_r3_round_bound: assert property (@(posedge clk) disable iff (rst)
    ring[STAGES-1].busy |-> (ring[STAGES-1].round <= LAST_RND));
endmodule

// File: rtl/sha_ring_dp.sv
module sha_ring_dp
  import sha_ring_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        stb,
  input  logic [255:0]   inChain,
  input  logic [511:0]   inBlock,
  output logic [255:0]   outDigest
);
  dpRec_t ring [STAGES];
  dpRec_t q, n0, n1, n2, n3;
  word_t  dg [8];

  // stage 0: feed-forward or load; h+K, Sigma1+Ch, Sigma0+Maj, sigma1+w9
  always_comb begin
    q = ring[STAGES-1];
    for (int i = 0; i < 8; i++) dg[i] = q.cv[i] + q.st[i];
    n0 = q;
    n0.pa = q.st[7] + kConst(stb.kIdx);
    n0.pb = bigSig1(q.st[4]) + chooseF(q.st[4], q.st[5], q.st[6]);
    n0.pz = bigSig0(q.st[0]) + majF(q.st[0], q.st[1], q.st[2]);
    n0.sa = smallSig1(q.w[14]) + q.w[9];
    if (stb.load) begin
      for (int i = 0; i < 8; i++) begin
        n0.st[i] = inChain[255-32*i -: 32];
        n0.cv[i] = inChain[255-32*i -: 32];
      end
      for (int i = 0; i < 16; i++) n0.w[i] = inBlock[511-32*i -: 32];
    end else if (stb.rehash) begin
      for (int i = 0; i < 8; i++) begin
        n0.st[i] = ivWord(3'(i));
        n0.cv[i] = ivWord(3'(i));
        n0.w[i]  = dg[i];
      end
      n0.w[8] = 32'h8000_0000;
      for (int i = 9; i < 15; i++) n0.w[i] = '0;
      n0.w[15] = 32'd256;
    end
  end

  // stage 1: add W[t]; sigma0(w1) + w0
  always_comb begin
    n1 = ring[0];
    n1.pa = ring[0].pa + ring[0].w[0];
    n1.sb = smallSig0(ring[0].w[1]) + ring[0].w[0];
  end

  // stage 2: T1 complete; new schedule word complete
  always_comb begin
    n2 = ring[1];
    n2.pa = ring[1].pa + ring[1].pb;
    n2.sa = ring[1].sa + ring[1].sb;
  end

  // stage 3: a' = T1 + T2, e' = d + T1, window slides
  always_comb begin
    n3 = ring[2];
    if (stb.run3) begin
      n3.st[0] = ring[2].pa + ring[2].pz;
      n3.st[4] = ring[2].st[3] + ring[2].pa;
      n3.st[1] = ring[2].st[0]; n3.st[2] = ring[2].st[1]; n3.st[3] = ring[2].st[2];
      n3.st[5] = ring[2].st[4]; n3.st[6] = ring[2].st[5]; n3.st[7] = ring[2].st[6];
      for (int i = 0; i < 15; i++) n3.w[i] = ring[2].w[i+1];
      n3.w[15] = ring[2].sa;
    end
  end

  always_ff @(posedge clk) begin
    ring[0] <= n0;
    ring[1] <= n1;
    ring[2] <= n2;
    ring[3] <= n3;
  end

  always_ff @(posedge clk) begin
    if (rst) outDigest <= '0;
    else if (stb.ffwd && !stb.rehash)
      for (int i = 0; i < 8; i++) outDigest[255-32*i -: 32] <= dg[i];
  end

  // R2: the digest port only changes on an edge that presents a result
  a_r2_digest_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(stb.ffwd && !stb.rehash) |-> $stable(outDigest));
endmodule

// File: rtl/sha256_ring_engine.sv
module sha256_ring_engine
  import sha_ring_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inDouble,
  input  logic [TAG_W-1:0] inTag,
  input  logic [255:0]     inChain,
  input  logic [511:0]     inBlock,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag,
  output logic [255:0]     outDigest
);
  strobe_t stb;

  sha_ring_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inDouble(inDouble), .inTag(inTag),
    .inReady(inReady), .outValid(outValid), .outTag(outTag), .stb(stb)
  );

  sha_ring_dp u_dp (
    .clk(clk), .rst(rst), .stb(stb), .inChain(inChain), .inBlock(inBlock),
    .outDigest(outDigest)
  );

  // R4: a result strobe never coincides with an acceptance at the entry boundary
  a_r4_no_collide: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !outValid);
endmodule

// File: tb/tb_sha256_ring_engine.sv
module tb_sha256_ring_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inDouble = 1'b0;
  logic inReady, outValid;
  logic [3:0] inTag = '0, outTag;
  logic [255:0] inChain = '0, outDigest;
  logic [511:0] inBlock = '0;

  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [511:0] BLK_ABC   = {32'h61626380, {14{32'h0}}, 32'h00000018};
  localparam logic [511:0] BLK_EMPTY = {32'h80000000, {15{32'h0}}};
  localparam logic [511:0] BLK_A     = {32'h61800000, {14{32'h0}}, 32'h00000008};
  localparam logic [511:0] BLK_LONG1 = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
                                        32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
                                        32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
                                        32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
  localparam logic [511:0] BLK_LONG2 = {{15{32'h0}}, 32'h000001c0};
  localparam logic [255:0] D_ABC   = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] D_EMPTY = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
  localparam logic [255:0] D_A     = 256'hca978112ca1bbdcafac231b39a23dc4da786eff8147c4e72b9807785afee48bb;
  localparam logic [255:0] D_LONG  = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
  localparam logic [255:0] D_DBL   = 256'h4f8b42c22dd3729b519ba6f68d2da7cc5b2d606d05daed5ad5128cc03e6c6358;

  int nVec = 0, nBad = 0, cyc = 0, nGot = 0;
  logic [255:0] gotDig [0:31];
  logic [3:0]   gotTag [0:31];
  int           gotCyc [0:31];

  sha256_ring_engine #(.TAG_W(4)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inDouble(inDouble),
    .inTag(inTag), .inChain(inChain), .inBlock(inBlock), .outValid(outValid),
    .outTag(outTag), .outDigest(outDigest)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && outValid && nGot < 32) begin
      gotDig[nGot] = outDigest;
      gotTag[nGot] = outTag;
      gotCyc[nGot] = cyc;
      nGot = nGot + 1;
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic submit(input logic [511:0] blk, input logic [255:0] cv, input logic dbl,
                        input logic [3:0] tag, output int acc);
    @(negedge clk);
    inValid = 1'b1; inBlock = blk; inChain = cv; inDouble = dbl; inTag = tag;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 acc = cyc;
  endtask

  task automatic idleIn();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitOut(input int n);
    while (nGot < n) @(posedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R7 outValid low after reset", 256'(outValid), 256'(0));
    chk("R7 inReady high after reset", 256'(inReady), 256'(1));
  endtask

  task automatic testSingle();
    int base, acc;
    base = nGot;
    submit(BLK_ABC, IV, 1'b0, 4'd5, acc);
    idleIn();
    waitOut(base + 1);
    chk("R2 abc digest", gotDig[base], D_ABC);
    chk("R3 single latency", 256'(gotCyc[base] - acc), 256'(260));
    chk("R4 tag returned", 256'(gotTag[base]), 256'(5));
    repeat (20) @(posedge clk);
    chk("R3 one-cycle strobe", 256'(nGot - base), 256'(1));
  endtask

  task automatic testFullRing();
    int base, a0, a1, a2, a3, a4, a5;
    base = nGot;
    submit(BLK_ABC, IV, 1'b0, 4'd1, a0);
    submit(BLK_EMPTY, IV, 1'b0, 4'd2, a1);
    submit(BLK_A, IV, 1'b0, 4'd3, a2);
    submit(BLK_LONG1, IV, 1'b0, 4'd4, a3);
    @(negedge clk);
    chk("R4 ready low with four in flight", 256'(inReady), 256'(0));
    chk("R4 back-to-back acceptance", 256'(a3 - a0), 256'(3));
    submit(BLK_A, IV, 1'b0, 4'd8, a4);
    idleIn();
    chk("R8 held offer taken after release", 256'(a4 - a0), 256'(264));
    waitOut(base + 5);
    chk("R4 order tag 1", 256'(gotTag[base]), 256'(1));
    chk("R4 order tag 2", 256'(gotTag[base+1]), 256'(2));
    chk("R4 order tag 3", 256'(gotTag[base+2]), 256'(3));
    chk("R4 order tag 4", 256'(gotTag[base+3]), 256'(4));
    chk("R1 held offer tag", 256'(gotTag[base+4]), 256'(8));
    chk("R2 abc in full ring", gotDig[base], D_ABC);
    chk("R2 empty message", gotDig[base+1], D_EMPTY);
    chk("R2 single-letter message", gotDig[base+2], D_A);
    chk("R1 held offer digest", gotDig[base+4], D_A);
    chk("R3 latency of fourth slot", 256'(gotCyc[base+3] - a3), 256'(260));
    submit(BLK_LONG2, gotDig[base+3], 1'b0, 4'd6, a5);
    idleIn();
    waitOut(base + 6);
    chk("R6 two-block digest", gotDig[base+5], D_LONG);
    chk("R6 tag", 256'(gotTag[base+5]), 256'(6));
  endtask

  task automatic testDouble();
    int base, acc;
    base = nGot;
    submit(BLK_ABC, IV, 1'b1, 4'd7, acc);
    idleIn();
    waitOut(base + 1);
    chk("R5 double digest", gotDig[base], D_DBL);
    chk("R5 double latency", 256'(gotCyc[base] - acc), 256'(520));
    chk("R5 tag", 256'(gotTag[base]), 256'(7));
    repeat (20) @(posedge clk);
    chk("R5 single presentation", 256'(nGot - base), 256'(1));
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    testReset();
    testSingle();
    testFullRing();
    testDouble();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule